// File: doc/BRIEF.md
# Multi-Word Stack Transfer Sequencer

This block carries out the block load and block store operations of a word-addressed stack machine. When the core hands it an operation code, a signed displacement, a word count and the current stack and frame pointers, it moves a run of consecutive words. The words go either from a memory region onto the top of the stack or from the top of the stack into a memory region. The region's base is the frame pointer, the pre-transfer stack pointer, or an address word held on the stack top, in each case plus the displacement.

The sequencer owns the shared word RAM while busy and issues at most one access per clock. That RAM has a one-cycle read latency. All source words are first gathered into a small internal buffer and then written out in ascending order. A copy whose source and destination overlap therefore behaves as if every source word were read before any destination word changed. At completion the block presents the new stack pointer and pulses done for one cycle.

Top module: `mwx_seq`

## Requirements
- R1: A transfer is accepted only when start_i is high while busy_o is low, op_i is one of 0x8A, 0x9A, 0x7E, 0xB2, 0xBA, 0xAE, and size_i is at most MAX_N (8). Any other start has no effect: there is no memory access, no done and no change of sp_o.
- R2: Op 0x8A (frame load) copies size words from mp+displ upward into sp+1 upward, and sp_o becomes sp+size.
- R3: Op 0x9A (stack-relative load) copies size words from sp+displ upward into sp+1 upward, using the sp given at start, and sp_o becomes sp+size.
- R4: Op 0x7E (indirect load) reads the address word A at M[sp], copies size words from A+displ upward into sp upward, overwriting A, and sp_o becomes sp+size-1.
- R5: Ops 0xB2 (frame store) and 0xBA (stack-relative store) copy the words at sp-size+1..sp into mp+displ or sp+displ upward, keeping their order, and sp_o becomes sp-size.
- R6: Op 0xAE (indirect store) reads the address word A at M[sp], copies the words at sp-size..sp-1 into A+displ upward, and sp_o becomes sp-size-1.
- R7: When the source and destination ranges overlap, the destination ends up holding the source words as they were before the transfer began.
- R8: A size of 0 raises done_o in the cycle after the accepting edge, with no memory access and no busy cycle. sp_o becomes sp, except for ops 0x7E and 0xAE, where it becomes sp-1.
- R9: done_o is high for exactly one cycle, with busy_o low in that cycle. sp_o changes only in a done cycle and holds its value otherwise. For size n>0, done_o appears 2n+2 cycles after the accepting edge, or 2n+4 cycles for ops 0x7E and 0xAE.
- R10: A transfer of size n makes exactly 2n memory accesses, plus one more read of M[sp] for ops 0x7E and 0xAE. Each access is one request in one cycle. A read returns its data on mem_rdata_i in the following cycle.
- R11: After reset, busy_o, done_o and mem_req_o are low and sp_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin a transfer |
| op_i | input | 8 | Operation code |
| displ_i | input | AW | Signed displacement, two's complement |
| size_i | input | NW | Word count |
| sp_i | input | AW | Stack pointer before the transfer |
| mp_i | input | AW | Frame pointer |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sp_o | output | AW | Stack pointer after the last completed transfer |
| mem_req_o | output | 1 | RAM access request |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | AW | RAM word address |
| mem_wdata_o | output | DW | RAM write data |
| mem_rdata_i | input | DW | RAM read data, one cycle after the request |

## Verification
The bench aims at overlapping copies: a stack-relative store whose destination sits one word above its source, and a load that reads words it also writes. A design that interleaved reads and writes would smear one word across the destination. Size-one runs of each op guard against off-by-one pointer arithmetic. In the indirect forms, failing to overwrite or pop the address word shows up in sp_o and in the stack slot itself. Zero-size runs catch a design that issues a stray access or leaves the address operand on the stack. Invalid codes, oversize counts and a start pulse in mid-transfer must leave memory and sp_o untouched.

// File: rtl/mwx_pkg.sv
package mwx_pkg;
  localparam logic [7:0] OP_LD_FRM = 8'h8A;
  localparam logic [7:0] OP_LD_STK = 8'h9A;
  localparam logic [7:0] OP_LD_IND = 8'h7E;
  localparam logic [7:0] OP_ST_FRM = 8'hB2;
  localparam logic [7:0] OP_ST_STK = 8'hBA;
  localparam logic [7:0] OP_ST_IND = 8'hAE;

  typedef enum logic [2:0] {
    S_IDLE, S_ADDR, S_AWAIT, S_RD, S_DRAIN, S_WR
  } seq_state_e;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_LD_FRM) || (op == OP_LD_STK) || (op == OP_LD_IND) ||
           (op == OP_ST_FRM) || (op == OP_ST_STK) || (op == OP_ST_IND);
  endfunction

  function automatic logic op_indirect(input logic [7:0] op);
    return (op == OP_LD_IND) || (op == OP_ST_IND);
  endfunction
endpackage

// File: rtl/mwx_addr_calc.sv
module mwx_addr_calc
  import mwx_pkg::*;
#(
  parameter int AW = 16,
  parameter int NW = 4
) (
  input  logic [7:0]    op_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] mp_i,
  input  logic [AW-1:0] displ_i,
  input  logic [NW-1:0] n_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] src_o,
  output logic [AW-1:0] dst_o,
  output logic [AW-1:0] sp_new_o
);
  localparam logic [AW-1:0] ONE = AW'(1);
  logic [AW-1:0] n_ext;
  assign n_ext = AW'(n_i);

  always_comb begin
    src_o    = '0;
    dst_o    = '0;
    sp_new_o = sp_i;
    unique case (op_i)
      OP_LD_FRM: begin
        src_o = mp_i + displ_i; dst_o = sp_i + ONE; sp_new_o = sp_i + n_ext;
      end
      OP_LD_STK: begin
        src_o = sp_i + displ_i; dst_o = sp_i + ONE; sp_new_o = sp_i + n_ext;
      end
      OP_LD_IND: begin
        src_o = base_i + displ_i; dst_o = sp_i; sp_new_o = sp_i + n_ext - ONE;
      end
      OP_ST_FRM: begin
        src_o = sp_i - n_ext + ONE; dst_o = mp_i + displ_i; sp_new_o = sp_i - n_ext;
      end
      OP_ST_STK: begin
        src_o = sp_i - n_ext + ONE; dst_o = sp_i + displ_i; sp_new_o = sp_i - n_ext;
      end
      OP_ST_IND: begin
        src_o = sp_i - n_ext; dst_o = base_i + displ_i; sp_new_o = sp_i - n_ext - ONE;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/mwx_wbuf.sv
module mwx_wbuf #(
  parameter int DW    = 32,
  parameter int DEPTH = 8,
  parameter int IW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             ent_q[g] <= '0;
      else if (we_i && widx_i == IW'(g))       ent_q[g] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (ridx_i == IW'(i)) rdata_o = ent_q[i];
    end
  end

  // R7: captures land inside the buffer
  p_widx_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |-> (widx_i < IW'(DEPTH)));
endmodule

// File: rtl/mwx_seq.sv
module mwx_seq
  import mwx_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int MAX_N = 8,
  localparam int NW   = $clog2(MAX_N + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    op_i,
  input  logic [AW-1:0] displ_i,
  input  logic [NW-1:0] size_i,
  input  logic [AW-1:0] sp_i,
  input  logic [AW-1:0] mp_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [AW-1:0] sp_o,
  output logic          mem_req_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i
);
  seq_state_e    state_q;
  logic [7:0]    op_q;
  logic [AW-1:0] sp_q, mp_q, d_q;
  logic [NW-1:0] n_q, idx_q, cap_idx_q;
  logic          cap_v_q, done_q;
  logic [AW-1:0] src_q, dst_q, spn_q, sp_out_q;

  logic          idle, accept, last_idx;
  logic [7:0]    c_op;
  logic [AW-1:0] c_sp, c_mp, c_d, c_src, c_dst, c_spn;
  logic [NW-1:0] c_n;
  logic [DW-1:0] buf_rdata;

  assign idle     = (state_q == S_IDLE);
  assign accept   = idle && start_i && op_known(op_i) && (size_i <= NW'(MAX_N));
  assign last_idx = (idx_q == n_q - NW'(1));

  // Idle: look at the request; otherwise: latched operands plus fetched base
  assign c_op = idle ? op_i    : op_q;
  assign c_sp = idle ? sp_i    : sp_q;
  assign c_mp = idle ? mp_i    : mp_q;
  assign c_d  = idle ? displ_i : d_q;
  assign c_n  = idle ? size_i  : n_q;

  mwx_addr_calc #(.AW(AW), .NW(NW)) u_calc (
    .op_i     (c_op),
    .sp_i     (c_sp),
    .mp_i     (c_mp),
    .displ_i  (c_d),
    .n_i      (c_n),
    .base_i   (mem_rdata_i[AW-1:0]),
    .src_o    (c_src),
    .dst_o    (c_dst),
    .sp_new_o (c_spn)
  );

  mwx_wbuf #(.DW(DW), .DEPTH(MAX_N), .IW(NW)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cap_v_q),
    .widx_i  (cap_idx_q),
    .wdata_i (mem_rdata_i),
    .ridx_i  (idx_q),
    .rdata_o (buf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= S_IDLE;
      op_q      <= '0;
      sp_q      <= '0;
      mp_q      <= '0;
      d_q       <= '0;
      n_q       <= '0;
      idx_q     <= '0;
      cap_idx_q <= '0;
      cap_v_q   <= 1'b0;
      done_q    <= 1'b0;
      src_q     <= '0;
      dst_q     <= '0;
      spn_q     <= '0;
      sp_out_q  <= '0;
    end else begin
      done_q    <= 1'b0;
      cap_v_q   <= (state_q == S_RD);
      cap_idx_q <= idx_q;
      unique case (state_q)
        S_IDLE: if (accept) begin
          op_q  <= op_i;
          sp_q  <= sp_i;
          mp_q  <= mp_i;
          d_q   <= displ_i;
          n_q   <= size_i;
          idx_q <= '0;
          src_q <= c_src;
          dst_q <= c_dst;
          spn_q <= c_spn;
          if (size_i == '0) begin
            done_q   <= 1'b1;
            sp_out_q <= c_spn;
          end else begin
            state_q <= op_indirect(op_i) ? S_ADDR : S_RD;
          end
        end
        S_ADDR:  state_q <= S_AWAIT;
        S_AWAIT: begin
          src_q   <= c_src;
          dst_q   <= c_dst;
          state_q <= S_RD;
        end
        S_RD: begin
          if (last_idx) begin
            idx_q   <= '0;
            state_q <= S_DRAIN;
          end else begin
            idx_q <= idx_q + NW'(1);
          end
        end
        S_DRAIN: state_q <= S_WR;
        S_WR: begin
          if (last_idx) begin
            state_q  <= S_IDLE;
            done_q   <= 1'b1;
            sp_out_q <= spn_q;
          end else begin
            idx_q <= idx_q + NW'(1);
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o      = !idle;
  assign done_o      = done_q;
  assign sp_o        = sp_out_q;
  assign mem_req_o   = (state_q == S_ADDR) || (state_q == S_RD) || (state_q == S_WR);
  assign mem_we_o    = (state_q == S_WR);
  assign mem_wdata_o = buf_rdata;

  always_comb begin
    unique case (state_q)
      S_ADDR:  mem_addr_o = sp_q;
      S_RD:    mem_addr_o = src_q + AW'(idx_q);
      S_WR:    mem_addr_o = dst_q + AW'(idx_q);
      default: mem_addr_o = '0;
    endcase
  end

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);

  p_zero_fast_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && size_i == '0) |=> (done_o && !busy_o));

  p_done_single_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_sp_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(sp_o));

  p_write_bound_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (idx_q < n_q));
endmodule

// File: tb/mwx_seq_tb.sv
module mwx_seq_tb;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int MAX_N = 8;
  localparam int NW = $clog2(MAX_N + 1);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0;
  logic [7:0]    op_i = '0;
  logic [AW-1:0] displ_i = '0;
  logic [NW-1:0] size_i = '0;
  logic [AW-1:0] sp_i = '0;
  logic [AW-1:0] mp_i = '0;
  logic          busy_o, done_o, mem_req_o, mem_we_o;
  logic [AW-1:0] sp_o, mem_addr_o;
  logic [DW-1:0] mem_wdata_o;
  logic [DW-1:0] mem_rdata_i = '0;

  int checks = 0;
  int errors = 0;
  int acc_cnt = 0;
  int cyc = 0;
  logic [DW-1:0] mem_m [256];
  logic [DW-1:0] ref_m [256];

  always #4 clk_i = ~clk_i;

  mwx_seq #(.AW(AW), .DW(DW), .MAX_N(MAX_N)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .op_i(op_i),
    .displ_i(displ_i), .size_i(size_i), .sp_i(sp_i), .mp_i(mp_i),
    .busy_o(busy_o), .done_o(done_o), .sp_o(sp_o), .mem_req_o(mem_req_o),
    .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_rdata_i(mem_rdata_i)
  );

  always @(posedge clk_i) begin
    cyc = cyc + 1;
    if (mem_req_o) begin
      acc_cnt = acc_cnt + 1;
      if (mem_we_o) mem_m[mem_addr_o[7:0]] = mem_wdata_o;
      else          mem_rdata_i <= mem_m[mem_addr_o[7:0]];
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    forever begin
      @(negedge clk_i);
      if (cyc > 150000) begin
        checks++; errors++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        finish_run();
      end
    end
  end

  function automatic string op_req(input logic [7:0] op);
    case (op)
      8'h8A: return "R2";
      8'h9A: return "R3";
      8'h7E: return "R4";
      8'hAE: return "R6";
      default: return "R5";
    endcase
  endfunction

  function automatic bit is_ind(input logic [7:0] op);
    return op == 8'h7E || op == 8'hAE;
  endfunction

  task automatic mem_compare(input string req);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < 256; i++)
      if (mem_m[i] !== ref_m[i]) begin bad++; if (first < 0) first = i; end
    chk(req, "memory mismatches", bad, 0);
    if (first >= 0) chk(req, "first bad word", mem_m[first], ref_m[first]);
  endtask

  task automatic run_op(input logic [7:0] op, input int d, input int n, input int sp,
                        input int mp, input int base, input bit poke, input string mreq);
    logic [AW-1:0] src, dst, spn, s16, m16, d16, n16, b16;
    logic [DW-1:0] tmp [MAX_N];
    int k, acc0, exp_lat, exp_acc;
    string rq;
    s16 = AW'(sp); m16 = AW'(mp); d16 = AW'(d); n16 = AW'(n); b16 = AW'(base);
    if (is_ind(op)) begin
      mem_m[s16[7:0]] = DW'(base);
      ref_m[s16[7:0]] = DW'(base);
    end
    case (op)
      8'h8A: begin src = m16 + d16; dst = s16 + 1; spn = s16 + n16; end
      8'h9A: begin src = s16 + d16; dst = s16 + 1; spn = s16 + n16; end
      8'h7E: begin src = b16 + d16; dst = s16;     spn = s16 + n16 - 1; end
      8'hB2: begin src = s16 - n16 + 1; dst = m16 + d16; spn = s16 - n16; end
      8'hBA: begin src = s16 - n16 + 1; dst = s16 + d16; spn = s16 - n16; end
      default: begin src = s16 - n16; dst = b16 + d16; spn = s16 - n16 - 1; end
    endcase
    for (int i = 0; i < n; i++) tmp[i] = ref_m[8'(src + AW'(i))];
    for (int i = 0; i < n; i++) ref_m[8'(dst + AW'(i))] = tmp[i];
    rq = (n == 0) ? "R8" : op_req(op);
    exp_lat = (n == 0) ? 1 : (2 * n + 2 + (is_ind(op) ? 2 : 0));
    exp_acc = (n == 0) ? 0 : (2 * n + (is_ind(op) ? 1 : 0));

    @(negedge clk_i);
    acc0 = acc_cnt;
    start_i = 1'b1; op_i = op; displ_i = d16; size_i = NW'(n); sp_i = s16; mp_i = m16;
    k = 0;
    forever begin
      @(negedge clk_i);
      k++;
      if (done_o || k > 300) break;
      start_i = 1'b0;
      if (poke && k == 2) begin
        start_i = 1'b1; op_i = 8'h8A; size_i = NW'(1); sp_i = '0; mp_i = '0;
      end
    end
    start_i = 1'b0;
    chk("R9", "latency to done", k, exp_lat);
    chk("R9", "busy in done cycle", busy_o, 1'b0);
    chk(rq, "sp_o", sp_o, spn);
    chk("R10", "access count", acc_cnt - acc0, exp_acc);
    mem_compare(mreq == "" ? rq : mreq);
    @(negedge clk_i);
    chk("R9", "done width", done_o, 1'b0);
  endtask

  task automatic run_ignored(input logic [7:0] op, input int n);
    logic [AW-1:0] sp0;
    int acc0, seen;
    sp0 = sp_o;
    @(negedge clk_i);
    acc0 = acc_cnt; seen = 0;
    start_i = 1'b1; op_i = op; size_i = NW'(n); sp_i = 16'd90; mp_i = 16'd80; displ_i = 16'd2;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk_i);
      start_i = 1'b0;
      if (done_o || busy_o) seen++;
    end
    chk("R1", "done/busy after ignored start", seen, 0);
    chk("R1", "accesses after ignored start", acc_cnt - acc0, 0);
    chk("R1", "sp_o after ignored start", sp_o, sp0);
    mem_compare("R1");
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) begin
      mem_m[i] = $urandom;
      ref_m[i] = mem_m[i];
    end
    repeat (3) @(negedge clk_i);
    chk("R11", "busy_o in reset", busy_o, 1'b0);
    chk("R11", "done_o in reset", done_o, 1'b0);
    chk("R11", "mem_req_o in reset", mem_req_o, 1'b0);
    chk("R11", "sp_o in reset", sp_o, '0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R11", "sp_o after reset", sp_o, '0);

    // size-one equivalence with single-word forms
    run_op(8'h8A, -2, 1, 100, 120, 0, 0, "R2");
    run_op(8'h9A, -1, 1, 100, 0, 0, 0, "R3");
    run_op(8'h7E, 3, 1, 110, 0, 60, 0, "R4");
    run_op(8'hB2, 2, 1, 110, 70, 0, 0, "R5");
    run_op(8'hBA, -3, 1, 110, 0, 0, 0, "R5");
    run_op(8'hAE, 1, 1, 110, 0, 150, 0, "R6");
    // wider runs
    run_op(8'h8A, 1, 8, 90, 140, 0, 0, "R2");
    run_op(8'h7E, -4, 5, 100, 0, 170, 0, "R4");
    run_op(8'hAE, 0, 4, 120, 0, 60, 0, "R6");
    // overlapping ranges
    run_op(8'hBA, -2, 4, 100, 0, 0, 0, "R7");
    run_op(8'h9A, -1, 3, 100, 0, 0, 0, "R7");
    run_op(8'h7E, 0, 3, 100, 0, 101, 0, "R7");
    // size zero
    run_op(8'h8A, 0, 0, 77, 60, 0, 0, "R8");
    run_op(8'h7E, 0, 0, 77, 60, 50, 0, "R8");
    run_op(8'hAE, 0, 0, 77, 60, 50, 0, "R8");
    run_op(8'hBA, 5, 0, 77, 60, 0, 0, "R8");
    // ignored starts
    run_ignored(8'h84, 2);
    run_ignored(8'h8A, 9);
    run_op(8'hB2, 2, 3, 130, 60, 0, 1, "R1");
    // random
    for (int r = 0; r < 60; r++) begin
      logic [7:0] op;
      int sel;
      sel = int'($urandom % 6);
      case (sel)
        0: op = 8'h8A; 1: op = 8'h9A; 2: op = 8'h7E;
        3: op = 8'hB2; 4: op = 8'hBA; default: op = 8'hAE;
      endcase
      run_op(op, int'($urandom % 13) - 6, int'($urandom % 9),
             40 + int'($urandom % 161), 40 + int'($urandom % 161),
             40 + int'($urandom % 161), ($urandom % 4) == 0, "");
    end
    finish_run();
  end
endmodule